// File: doc/BRIEF.md
# Board Interrupt Aggregator with Presence Signature

This block sits on a small register bus and gathers up to sixteen level-sensitive interrupt requests from peripherals on a plug-in board into a single active-low level interrupt for the host. Each request passes through a two-flop synchronizer. It then sets a sticky status bit. A status bit stays set until software drops it through a separate clear register. A mask register decides which pending bits may drive the host line, where a 1 disables a line. The combined output is registered.

Software also uses the block to detect the board. Three fixed signature words and a code-version word can be read at set offsets. If the signature words match, the board is present. A typical driver disables every line and then pulses the clear register with all ones followed by all zeros. It then writes the mask so that only the lines it services are enabled.

Top module: `dbg_irq_aggregator`

## Requirements
- R1: After reset the mask register reads 0xFFFF, the status and clear registers read 0x0000, and `host_irq_n` is high.
- R2: Reads return 0xAAAA at offset 0x40, 0x5555 at offset 0x48, 0xCAFE at offset 0x58, and the `VERSION` parameter at offset 0x50.
- R3: A read of any offset other than 0x10, 0x20, 0x38, 0x40, 0x48, 0x50 or 0x58 returns 0x0000. A write to the status (0x10), signature or version offsets changes nothing that can be read back.
- R4: Bit n of `irq_in` going high sets status bit n (offset 0x10) on the third rising clock edge after the change. The bit then stays set after the input falls, until it is cleared.
- R5: Mask bit n (offset 0x38) set to 1 keeps line n off the host interrupt. A bit set to 0 lets it through. `host_irq_n` follows a mask or status change one clock later.
- R6: From the edge after clear-register bit n (offset 0x20) becomes 1, status bit n is held at 0 and events on line n are ignored. Other status bits are unaffected. Once the clear bit returns to 0, line n latches events again.
- R7: `host_irq_n` stays low while at least one unmasked status bit is set. It returns high one clock after the last such bit is cleared.
- R8: The mask and clear registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_in | input | NUM_LINES | Asynchronous level interrupt requests, active high |
| host_irq_n | output | 1 | Combined level interrupt to the host, active low |

## Verification
The bench checks the exact synchronizer latency by sampling status one edge early and on time. A design with a single flop, or an extra one, shows the bit in the wrong cycle. It holds a clear bit while the matching line pulses to show that the event is ignored, not latched and released later. A design that only clears on the write edge would show the bit again. It keeps a second unmasked line pending while the first is cleared, and runs the post-init mask 0x1F with line 0 raised. An OR over raw status, or an inverted mask sense, would move the host line wrongly in those two cases.

// File: rtl/dbg_irq_pkg.sv
package dbg_irq_pkg;

    localparam int REG_W = 16;

    typedef logic [REG_W-1:0] word_t;

    localparam logic [15:0] OFF_STATUS  = 16'h0010;
    localparam logic [15:0] OFF_CLEAR   = 16'h0020;
    localparam logic [15:0] OFF_MASK    = 16'h0038;
    localparam logic [15:0] OFF_SIG_A   = 16'h0040;
    localparam logic [15:0] OFF_SIG_B   = 16'h0048;
    localparam logic [15:0] OFF_VERSION = 16'h0050;
    localparam logic [15:0] OFF_SIG_C   = 16'h0058;

    localparam word_t SIG_A_VAL = 16'hAAAA;
    localparam word_t SIG_B_VAL = 16'h5555;
    localparam word_t SIG_C_VAL = 16'hCAFE;

    localparam word_t MASK_RST_VAL = 16'hFFFF;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_CLEAR,
        SEL_MASK,
        SEL_SIG_A,
        SEL_SIG_B,
        SEL_VERSION,
        SEL_SIG_C
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
        word_t    data;
    } bus_req_t;

    function automatic reg_sel_e decode_offset(input logic [15:0] off);
        reg_sel_e s;
        case (off)
            OFF_STATUS:  s = SEL_STATUS;
            OFF_CLEAR:   s = SEL_CLEAR;
            OFF_MASK:    s = SEL_MASK;
            OFF_SIG_A:   s = SEL_SIG_A;
            OFF_SIG_B:   s = SEL_SIG_B;
            OFF_VERSION: s = SEL_VERSION;
            OFF_SIG_C:   s = SEL_SIG_C;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irq_in_sync.sv
module irq_in_sync #(
    parameter int N      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    logic [N-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] event_in,
    input  logic [N-1:0] hold_clr,
    output logic [N-1:0] status
);
    logic [N-1:0] status_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)              status_q[i] <= 1'b0;
            else if (hold_clr[i]) status_q[i] <= 1'b0;
            else if (event_in[i]) status_q[i] <= 1'b1;
        end
    end

    assign status = status_q;
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
    import dbg_irq_pkg::*;
#(
    parameter int    N       = 16,
    parameter word_t VERSION = 16'h0103
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_req_t     req,
    input  logic [N-1:0] status,
    output word_t        mask_q,
    output word_t        clr_q,
    output word_t        rdata
);
    word_t status_w;

    always_comb begin
        status_w        = '0;
        status_w[N-1:0] = status;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= MASK_RST_VAL;
            clr_q  <= '0;
        end else if (req.wr) begin
            if (req.sel == SEL_MASK)  mask_q <= req.data;
            if (req.sel == SEL_CLEAR) clr_q  <= req.data;
        end
    end

    always_comb begin
        case (req.sel)
            SEL_STATUS:  rdata = status_w;
            SEL_CLEAR:   rdata = clr_q;
            SEL_MASK:    rdata = mask_q;
            SEL_SIG_A:   rdata = SIG_A_VAL;
            SEL_SIG_B:   rdata = SIG_B_VAL;
            SEL_VERSION: rdata = VERSION;
            SEL_SIG_C:   rdata = SIG_C_VAL;
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] status,
    input  logic [N-1:0] disable_bits,
    output logic         irq_n
);
    logic irq_n_q;

    always_ff @(posedge clk) begin
        if (rst) irq_n_q <= 1'b1;
        else     irq_n_q <= ~(|(status & ~disable_bits));
    end

    assign irq_n = irq_n_q;
endmodule

// File: rtl/dbg_irq_aggregator.sv
module dbg_irq_aggregator
    import dbg_irq_pkg::*;
#(
    parameter int    ADDR_W    = 8,
    parameter int    NUM_LINES = 16,
    parameter int    SYNC_LEN  = 2,
    parameter word_t VERSION   = 16'h0103
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [15:0]          bus_wdata,
    output logic [15:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic                 host_irq_n
);
    bus_req_t             req;
    logic [NUM_LINES-1:0] sync_evt;
    logic [NUM_LINES-1:0] status_q;
    word_t                mask_q;
    word_t                clr_q;

    always_comb begin
        req.wr   = bus_wr;
        req.sel  = decode_offset(16'(bus_addr));
        req.data = bus_wdata;
    end

    irq_in_sync #(.N(NUM_LINES), .STAGES(SYNC_LEN)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (irq_in),
        .sync_out (sync_evt)
    );

    irq_status_bank #(.N(NUM_LINES)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .event_in (sync_evt),
        .hold_clr (clr_q[NUM_LINES-1:0]),
        .status   (status_q)
    );

    irq_reg_file #(.N(NUM_LINES), .VERSION(VERSION)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .status (status_q),
        .mask_q (mask_q),
        .clr_q  (clr_q),
        .rdata  (bus_rdata)
    );

    irq_out_stage #(.N(NUM_LINES)) u_out (
        .clk          (clk),
        .rst          (rst),
        .status       (status_q),
        .disable_bits (mask_q[NUM_LINES-1:0]),
        .irq_n        (host_irq_n)
    );
endmodule

// File: rtl/dbg_irq_aggregator_chk.sv
module dbg_irq_aggregator_chk
    import dbg_irq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_LINES = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [15:0]          bus_rdata,
    input logic [NUM_LINES-1:0] status,
    input logic [15:0]          mask,
    input logic [15:0]          clr,
    input logic                 host_irq_n
);
    logic [NUM_LINES-1:0] pend;
    logic [NUM_LINES-1:0] clr_bits;

    assign pend     = status & ~mask[NUM_LINES-1:0];
    assign clr_bits = clr[NUM_LINES-1:0];

    AST_IRQ_ASSERTS: assert property (@(posedge clk) disable iff (rst)
        (|pend) |=> !host_irq_n); // R5

    AST_IRQ_RELEASES: assert property (@(posedge clk) disable iff (rst)
        !(|pend) |=> host_irq_n); // R7

    AST_CLEAR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (|clr_bits) |=> ((status & $past(clr_bits)) == '0)); // R6

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (|status) |=> (((($past(status) & ~$past(clr_bits))) & ~status) == '0)); // R4

    AST_SIG_A_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(OFF_SIG_A)) |-> (bus_rdata == SIG_A_VAL)); // R2

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == '0) |-> (bus_rdata == '0)); // R3
endmodule

bind dbg_irq_aggregator dbg_irq_aggregator_chk #(
    .ADDR_W    (ADDR_W),
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .status     (status_q),
    .mask       (mask_q),
    .clr        (clr_q),
    .host_irq_n (host_irq_n)
);

// File: tb/dbg_irq_aggregator_bench.sv
module dbg_irq_aggregator_bench;
    localparam logic [15:0] VER = 16'h0103;
    localparam logic [7:0] A_STAT = 8'h10, A_CLR = 8'h20, A_MASK = 8'h38,
                           A_SIGA = 8'h40, A_SIGB = 8'h48, A_VER = 8'h50, A_SIGC = 8'h58;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] irq_in = '0;
    logic        host_irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    dbg_irq_aggregator #(.VERSION(VER)) u_dbg_irq_aggregator (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .host_irq_n(host_irq_n)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [7:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        peek(A_MASK, v); check("R1 mask reset", v, 16'hFFFF);
        peek(A_STAT, v); check("R1 status reset", v, 16'h0000);
        peek(A_CLR, v);  check("R1 clear reset", v, 16'h0000);
        check("R1 host_irq_n reset", {15'd0, host_irq_n}, 16'h0001);
    endtask

    task automatic t_map;
        logic [15:0] v;
        peek(A_SIGA, v); check("R2 sig A", v, 16'hAAAA);
        peek(A_SIGB, v); check("R2 sig B", v, 16'h5555);
        peek(A_SIGC, v); check("R2 sig C", v, 16'hCAFE);
        peek(A_VER, v);  check("R2 version", v, VER);
        peek(8'h00, v);  check("R3 unmapped 0x00", v, 16'h0000);
        peek(8'h30, v);  check("R3 unmapped 0x30", v, 16'h0000);
        peek(8'h41, v);  check("R3 unmapped 0x41", v, 16'h0000);
        wr(A_SIGA, 16'h1234);
        peek(A_SIGA, v); check("R3 sig write ignored", v, 16'hAAAA);
        wr(A_VER, 16'h0000);
        peek(A_VER, v);  check("R3 version write ignored", v, VER);
        wr(A_STAT, 16'hFFFF);
        cycles(1);
        peek(A_STAT, v); check("R3 status write ignored", v, 16'h0000);
    endtask

    task automatic t_latch;
        logic [15:0] v;
        @(negedge clk);
        irq_in[3] = 1'b1;
        peek(A_STAT, v);
        cycles(2);
        peek(A_STAT, v); check("R4 not yet after two edges", v, 16'h0000);
        cycles(1);
        peek(A_STAT, v); check("R4 set on third edge", v, 16'h0008);
        irq_in[3] = 1'b0;
        cycles(4);
        peek(A_STAT, v); check("R4 sticky after input falls", v, 16'h0008);
        check("R5 all masked keeps irq high", {15'd0, host_irq_n}, 16'h0001);
    endtask

    task automatic t_mask;
        logic [15:0] v;
        wr(A_MASK, 16'hFFF7);
        check("R5 irq not yet low at write edge", {15'd0, host_irq_n}, 16'h0001);
        cycles(1);
        check("R5 irq low one clock after unmask", {15'd0, host_irq_n}, 16'h0000);
        peek(A_MASK, v); check("R8 mask readback", v, 16'hFFF7);
    endtask

    task automatic t_clear;
        logic [15:0] v;
        @(negedge clk);
        irq_in[9] = 1'b1;
        cycles(3);
        irq_in[9] = 1'b0;
        wr(A_MASK, 16'hFDF7);
        wr(A_CLR, 16'h0008);
        peek(A_CLR, v);  check("R8 clear readback", v, 16'h0008);
        cycles(1);
        peek(A_STAT, v); check("R6 bit3 cleared, bit9 kept", v, 16'h0200);
        cycles(1);
        check("R7 irq stays low with line 9 pending", {15'd0, host_irq_n}, 16'h0000);
        irq_in[3] = 1'b1;
        cycles(4);
        irq_in[3] = 1'b0;
        cycles(3);
        peek(A_STAT, v); check("R6 event ignored while clear held", v, 16'h0200);
        wr(A_CLR, 16'h0000);
        cycles(1);
        peek(A_STAT, v); check("R6 no late release after clear drops", v, 16'h0200);
        irq_in[3] = 1'b1;
        cycles(4);
        irq_in[3] = 1'b0;
        peek(A_STAT, v); check("R6 relatches after clear drops", v, 16'h0208);
        wr(A_CLR, 16'hFFFF);
        wr(A_CLR, 16'h0000);
        peek(A_STAT, v); check("R6 clear-all pulse", v, 16'h0000);
        cycles(1);
        check("R7 irq high after last pending cleared", {15'd0, host_irq_n}, 16'h0001);
    endtask

    task automatic t_init_mask;
        wr(A_MASK, 16'h001F);
        @(negedge clk);
        irq_in[0] = 1'b1;
        cycles(5);
        check("R5 line 0 masked by 0x1F", {15'd0, host_irq_n}, 16'h0001);
        irq_in[5] = 1'b1;
        cycles(3);
        check("R5 line 5 not yet through", {15'd0, host_irq_n}, 16'h0001);
        cycles(1);
        check("R5 line 5 enabled by 0x1F", {15'd0, host_irq_n}, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_latch();
        t_mask();
        t_clear();
        t_init_mask();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule